// File: doc/BRIEF.md
# Multi-Port Injection Port Selector

This block sits in the network interface of an end node that has links to as many as four neighbouring mesh routers. Each cycle it looks at one pending message and picks the injection port to use. It takes the node's own coordinates, the destination node's coordinates, and a busy flag and a credit flag for each port. Ports that lead along a minimal path are preferred. If none of them can accept the message, the block falls back to the free port with the fewest hops.

A 16-bit LFSR breaks ties between equal candidates, so that traffic spreads across the routers. When no port can take the message, the grant stays empty and the selection is evaluated again on the next cycle. The grant is combinational from the inputs and the current LFSR state. While one message holds a port busy, the next message is steered elsewhere, and all four links can carry injections at the same time.

Port k connects to the router at (self_x + k%2, self_y + k/2). A static parameter masks the ports that are not wired on boundary and corner nodes.

Top module: `inj_port_sel`

## Requirements
- R1: While rst_ni is low the LFSR holds SEED. Whenever req_i is low, grant_o and grant_min_o are both zero.
- R2: Port k is free only when its PORT_PRESENT bit is 1, busy_i[k] is 0 and credit_i[k] is 1, and only a free port is granted. A granted port that then reads busy steers the next message to a different port, so all four ports can be injecting at once.
- R3: The hop cost of port k is |ax| + |ay|. Here ax is the distance from the router column self_x + (k%2) to the closed interval [dst_x, dst_x+1], and ay is the distance from the router row self_y + (k/2) to [dst_y, dst_y+1]. A port is minimal when its cost equals the lowest cost among present ports.
- R4: If at least one free port is minimal, the grant goes to a minimal port and grant_min_o is 1.
- R5: If no free port is minimal, the grant goes to a free port whose cost is the lowest among free ports, and grant_min_o is 0.
- R6: With req_i high and no free port, grant_o is zero, and the choice is re-evaluated from the inputs on every following cycle.
- R7: grant_o is one-hot or all zero.
- R8: The LFSR is 16 bits wide. On each clock edge out of reset it shifts left by one, with bit 0 taking the XOR of bits 15, 13, 12 and 10. Its low two bits give the start index of the tie-break.
- R9: Among the candidate ports, the one granted is the first candidate found when scanning upward from the start index and wrapping from port 3 back to port 0.
- R10: A port whose PORT_PRESENT bit is 0 is never granted, and its cost plays no part in deciding which ports are minimal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | A message is waiting for injection |
| self_x_i | input | CW | Column of this end node |
| self_y_i | input | CW | Row of this end node |
| dst_x_i | input | CW | Column of the destination node |
| dst_y_i | input | CW | Row of the destination node |
| busy_i | input | NP | Per port: an injection is in progress |
| credit_i | input | NP | Per port: the router has buffer space for a new message |
| grant_o | output | NP | One-hot chosen port, or zero for no choice |
| grant_min_o | output | 1 | The chosen port lies on a minimal path |

## Verification
The first pattern uses a destination at which every router ties at cost zero. The grant then follows the LFSR low bits directly, which exposes a wrong seed, wrong taps or a wrong scan start. A second pattern uses a destination far to the east. Only the two eastern ports are minimal there, and masking them one at a time separates the minimal choice, the shortest fallback and the empty-grant retry. Tie sets with gaps and wrap-around, credit-starved ports, and a run of messages that each occupy the port they were granted check the availability filter and the scan order. Long random runs over coordinates, busy masks and credit masks are compared against a behavioural model, both for a fully wired node and for a node with only two ports present.

// File: rtl/inj_sel_pkg.sv
package inj_sel_pkg;
  localparam int LFSR_W = 16;
  // feedback from bits 15, 13, 12, 10
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/inj_sel_lfsr.sv
module inj_sel_lfsr
  import inj_sel_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter int IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [IW-1:0] start_o
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  assign fb = ^(state_q & LFSR_TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {state_q[LFSR_W-2:0], fb};
  end

  assign start_o = state_q[IW-1:0];
endmodule

// File: rtl/inj_sel_hops.sv
module inj_sel_hops #(
  parameter int CW = 4,
  parameter int HW = 6,
  parameter int OX = 0,
  parameter int OY = 0
) (
  input  logic [CW-1:0] self_x_i,
  input  logic [CW-1:0] self_y_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_y_i,
  output logic [HW-1:0] hops_o
);
  logic [CW:0] rx, ry, ax, ay;

  // distance from router coordinate to the two-wide span of the target node
  function automatic logic [CW:0] span_dist(input logic [CW:0] r, input logic [CW:0] lo);
    if (r < lo)              return lo - r;
    else if (r > lo + 1'b1)  return r - lo - 1'b1;
    else                     return '0;
  endfunction

  assign rx = {1'b0, self_x_i} + (CW+1)'(OX);
  assign ry = {1'b0, self_y_i} + (CW+1)'(OY);
  assign ax = span_dist(rx, {1'b0, dst_x_i});
  assign ay = span_dist(ry, {1'b0, dst_y_i});
  assign hops_o = HW'(ax) + HW'(ay);
endmodule

// File: rtl/inj_sel_rotpick.sv
module inj_sel_rotpick #(
  parameter int NP = 4,
  parameter int IW = 2
) (
  input  logic [NP-1:0] cand_i,
  input  logic [IW-1:0] start_i,
  output logic [NP-1:0] pick_o
);
  always_comb begin
    int s;
    int idx;
    logic found;
    s = int'(start_i) % NP;
    found = 1'b0;
    pick_o = '0;
    for (int i = 0; i < NP; i++) begin
      idx = (s + i) % NP;
      if (!found && cand_i[idx]) begin
        pick_o[idx] = 1'b1;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/inj_port_sel.sv
module inj_port_sel
  import inj_sel_pkg::*;
#(
  parameter int NP = 4,
  parameter int CW = 4,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter logic [NP-1:0] PORT_PRESENT = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [CW-1:0] self_x_i,
  input  logic [CW-1:0] self_y_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_y_i,
  input  logic [NP-1:0] busy_i,
  input  logic [NP-1:0] credit_i,
  output logic [NP-1:0] grant_o,
  output logic          grant_min_o
);
  localparam int HW = CW + 2;
  localparam int IW = (NP > 1) ? $clog2(NP) : 1;

  logic [IW-1:0] start;
  logic [HW-1:0] hops [NP];
  logic [HW-1:0] min_all, min_av;
  logic [NP-1:0] avail, cand, is_min, pick;

  inj_sel_lfsr #(.SEED(SEED), .IW(IW)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_o (start)
  );

  for (genvar p = 0; p < NP; p++) begin : g_hop
    inj_sel_hops #(.CW(CW), .HW(HW), .OX(p % 2), .OY(p / 2)) u_hop (
      .self_x_i (self_x_i),
      .self_y_i (self_y_i),
      .dst_x_i  (dst_x_i),
      .dst_y_i  (dst_y_i),
      .hops_o   (hops[p])
    );
  end

  assign avail = PORT_PRESENT & ~busy_i & credit_i;

  always_comb begin
    min_all = '1;
    min_av  = '1;
    for (int p = 0; p < NP; p++) begin
      if (PORT_PRESENT[p] && hops[p] < min_all) min_all = hops[p];
      if (avail[p] && hops[p] < min_av)         min_av  = hops[p];
    end
    for (int p = 0; p < NP; p++) begin
      cand[p]   = avail[p] && (hops[p] == min_av);
      is_min[p] = PORT_PRESENT[p] && (hops[p] == min_all);
    end
  end

  inj_sel_rotpick #(.NP(NP), .IW(IW)) u_pick (
    .cand_i  (cand),
    .start_i (start),
    .pick_o  (pick)
  );

  assign grant_o     = req_i ? pick : '0;
  assign grant_min_o = |(grant_o & is_min);
endmodule

// File: rtl/inj_port_sel_chk.sv
module inj_port_sel_chk #(
  parameter int NP = 4,
  parameter logic [NP-1:0] PORT_PRESENT = '1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [NP-1:0] busy_i,
  input logic [NP-1:0] credit_i,
  input logic [NP-1:0] grant_o,
  input logic          grant_min_o
);
  logic [NP-1:0] free_w;
  assign free_w = PORT_PRESENT & ~busy_i & credit_i;

  p_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  p_only_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & (busy_i | ~credit_i)) == '0);

  p_absent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~PORT_PRESENT) == '0);

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (grant_o == '0 && !grant_min_o));

  p_retry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && free_w == '0) |-> grant_o == '0);

  p_serve_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && free_w != '0) |-> grant_o != '0);

  p_min_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_min_o |-> grant_o != '0);
endmodule

bind inj_port_sel inj_port_sel_chk #(.NP(NP), .PORT_PRESENT(PORT_PRESENT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .busy_i      (busy_i),
  .credit_i    (credit_i),
  .grant_o     (grant_o),
  .grant_min_o (grant_min_o)
);

// File: tb/inj_port_sel_test.sv
module inj_port_sel_test;
  localparam int NP = 4;
  localparam int CW = 4;
  localparam logic [15:0] SEED = 16'h1D2B;
  localparam int EDGE_MASK = 4'b0011;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic          req = 1'b0;
  logic [CW-1:0] sx = '0, sy = '0, dx = '0, dy = '0;
  logic [NP-1:0] busy = '0, cred = '0;
  logic [NP-1:0] grant, e_grant;
  logic          gmin, e_gmin;

  inj_port_sel #(.NP(NP), .CW(CW), .SEED(SEED), .PORT_PRESENT(4'b1111)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req),
    .self_x_i(sx), .self_y_i(sy), .dst_x_i(dx), .dst_y_i(dy),
    .busy_i(busy), .credit_i(cred), .grant_o(grant), .grant_min_o(gmin));

  inj_port_sel #(.NP(NP), .CW(CW), .SEED(SEED), .PORT_PRESENT(4'b0011)) uut_edge (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req),
    .self_x_i(sx), .self_y_i(sy), .dst_x_i(dx), .dst_y_i(dy),
    .busy_i(busy), .credit_i(cred), .grant_o(e_grant), .grant_min_o(e_gmin));

  int  n_cmp = 0;
  int  n_bad = 0;
  int  m_lfsr = int'(SEED);
  bit  done = 1'b0;

  function automatic int lfsr_next(int s);
    int fb;
    fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
    return ((s << 1) | fb) & 16'hFFFF;
  endfunction

  function automatic int axis_gap(int r, int lo);
    if (r < lo) return lo - r;
    if (r > lo + 1) return r - lo - 1;
    return 0;
  endfunction

  task automatic model(input int present, output int g, output int gm, output string tag);
    int cost [4];
    int fr [4];
    int lo_all, lo_fr, any, st;
    lo_all = 1000; lo_fr = 1000; any = 0;
    for (int k = 0; k < 4; k++) begin
      cost[k] = axis_gap(int'(sx) + k % 2, int'(dx)) + axis_gap(int'(sy) + k / 2, int'(dy));
      fr[k] = ((present >> k) & 1) && !busy[k] && cred[k];
      if (((present >> k) & 1) && cost[k] < lo_all) lo_all = cost[k];
      if (fr[k] && cost[k] < lo_fr) lo_fr = cost[k];
      if (fr[k]) any = 1;
    end
    g = 0; gm = 0;
    st = m_lfsr & 3;
    if (!req) tag = "R1";
    else if (!any) tag = "R6";
    else begin
      for (int i = 0; i < 4; i++) begin
        int k;
        k = (st + i) % 4;
        if (g == 0 && fr[k] && cost[k] == lo_fr) g = 1 << k;
      end
      for (int k = 0; k < 4; k++)
        if (((g >> k) & 1) && cost[k] == lo_all) gm = 1;
      tag = gm ? "R4" : "R5";
    end
  endtask

  task automatic check(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  // compares both instances; an empty tag lets the model classify the case
  task automatic compare_all(input string tag);
    int g, gm, eg, egm, ones;
    string t, et;
    model(4'b1111, g, gm, t);
    model(EDGE_MASK, eg, egm, et);
    check((tag == "") ? t : tag, int'(grant) | (int'(gmin) << 4), g | (gm << 4));
    check("R10", int'(e_grant) | (int'(e_gmin) << 4), eg | (egm << 4));
    ones = $countones(grant);
    check("R7", (ones <= 1) ? 1 : 0, 1);
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_ni) m_lfsr = lfsr_next(m_lfsr);
    #1;
  endtask

  task automatic step(input logic r, input int x0, input int y0, input int x1, input int y1,
                      input int b, input int c, input string tag);
    tick();
    req = r; sx = CW'(x0); sy = CW'(y0); dx = CW'(x1); dy = CW'(y1);
    busy = NP'(b); cred = NP'(c);
    #1;
    compare_all(tag);
  endtask

  initial begin
    // R1: reset and idle
    for (int i = 0; i < 3; i++) step(1'b0, 2, 2, 2, 2, 0, 15, "R1");
    tick();
    rst_ni = 1'b1;
    for (int i = 0; i < 2; i++) step(1'b0, 2, 2, 2, 2, 0, 15, "R1");

    // R8: all four routers tie at cost 0, grant tracks LFSR low bits
    for (int i = 0; i < 20; i++) step(1'b1, 2, 2, 2, 2, 0, 15, "R8");

    // R3: destination east; ports 1 and 3 cost 4, ports 0 and 2 cost 5
    step(1'b1, 0, 0, 5, 0, 0, 15, "R3");
    step(1'b1, 0, 0, 5, 0, 0, 15, "R3");
    step(1'b1, 0, 0, 5, 0, 4'b0010, 15, "R4");
    step(1'b1, 0, 0, 5, 0, 4'b1010, 15, "R5");
    step(1'b1, 0, 0, 5, 0, 4'b1011, 15, "R5");
    step(1'b1, 0, 0, 5, 0, 0, 0, "R6");
    step(1'b1, 0, 0, 5, 0, 4'b1111, 15, "R6");
    step(1'b1, 0, 0, 5, 0, 0, 15, "R6");

    // R9: gapped tie set with wrap-around
    for (int i = 0; i < 10; i++) step(1'b1, 2, 2, 2, 2, 4'b0110, 15, "R9");
    for (int i = 0; i < 10; i++) step(1'b1, 2, 2, 2, 2, 4'b0011, 15, "R9");

    // R2: credit-starved ports
    for (int i = 0; i < 8; i++) step(1'b1, 2, 2, 2, 2, 0, 4'b0101, "R2");

    // R2: each granted port becomes busy; four distinct grants, then none
    begin
      int acc;
      acc = 0;
      for (int i = 0; i < 5; i++) begin
        step(1'b1, 2, 2, 2, 2, acc, 15, "R2");
        check("R2", ((int'(grant) & acc) == 0) ? 1 : 0, 1);
        acc = acc | int'(grant);
      end
      check("R2", acc, 15);
    end

    // random sweep
    for (int i = 0; i < 4000; i++)
      step(($urandom_range(0, 7) != 0), $urandom_range(0, 15), $urandom_range(0, 15),
           $urandom_range(0, 15), $urandom_range(0, 15),
           $urandom_range(0, 15) & $urandom_range(0, 15), $urandom_range(0, 15) | $urandom_range(0, 15), "");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule